// File: doc/BRIEF.md
# Dark-Row Column Offset Corrector

This block cleans column-dependent fixed offsets out of digitized sensor data. Each frame opens with one row taken from pixels that are fully shielded from light; that row holds nothing but the offset each column's readout chain adds. The block keeps those values, one word per column, and for every image row that follows, it subtracts the matching column's stored value from each incoming pixel. The dark row itself is consumed and never appears at the output. Correction takes place on digital samples, after conversion and ahead of any later pairing or sum/difference stage.

The input is a pixel stream with a valid strobe and two markers: one on the first pixel of a frame, which is also the first pixel of its dark row, and one on the first pixel of every row. Corrected pixels leave one cycle later with their own valid strobe and a row-start marker. Corrected values that would go negative are held at zero. Until a dark row has been seen after reset the block passes pixels through unchanged and raises a status bit to say it is not calibrated.

Top module: `dark_ref_sub`

## Requirements
- R1: After reset, out_valid is 0 and uncalibrated is 1.
- R2: The row begun by a pixel with in_frame_start = 1 is the dark row; none of its pixels, up to the next pixel with in_row_start = 1 and in_frame_start = 0, raises out_valid.
- R3: Dark-row pixels are stored by column index, where the pixel carrying a start marker is column 0 and each later accepted pixel of the row takes the next index.
- R4: An accepted image-row pixel at column c produces, exactly one cycle later, out_valid = 1 and out_data = in_data minus the stored dark value of column c.
- R5: When the stored dark value exceeds the pixel, out_data is 0 (no wrap-around).
- R6: uncalibrated stays 1, and pixels pass through unchanged, until the first dark-row pixel is accepted; from the next cycle on it is 0 and stays 0 until reset.
- R7: out_row_start is 1 exactly on the output of a pixel that carried in_row_start = 1.
- R8: A cycle with in_valid = 0 produces no output and does not advance the column index.
- R9: A new frame's dark row replaces the stored values column by column; the following rows are corrected against the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_data | input | PIX_W | Digitized pixel value |
| in_frame_start | input | 1 | First pixel of a frame (opens the dark row) |
| in_row_start | input | 1 | First pixel of a row |
| out_valid | output | 1 | Corrected pixel strobe |
| out_data | output | PIX_W | Offset-corrected pixel |
| out_row_start | output | 1 | First corrected pixel of a row |
| uncalibrated | output | 1 | No dark row captured since reset |

## Verification
Two functions meet in one cycle when frames run back to back: the first pixel of a new frame's dark row is written into the column store on the same edge that the output register delivers the final corrected pixel of the previous frame. The bench provokes this by sending a second frame with different dark values immediately after the last image pixel, with no idle gap, and judges it by the scoreboard: the last pixel of the old frame must still carry the old offset, while the rows of the new frame must carry the new one.

// File: rtl/dark_ref_pkg.sv
package dark_ref_pkg;
  // Subtract with a floor at zero; operands are zero-extended pixel words.
  function automatic logic [31:0] floor_sub(input logic [31:0] pix, input logic [31:0] offs);
    return (pix > offs) ? (pix - offs) : 32'd0;
  endfunction
endpackage

// File: rtl/col_tracker.sv
module col_tracker #(
  parameter int NCOLS = 64,
  localparam int CW = (NCOLS > 1) ? $clog2(NCOLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          row_start,
  input  logic          frame_start,
  output logic [CW-1:0] col,
  output logic          dark_now
);
  logic [CW-1:0] next_q;
  logic          dark_q;

  assign col      = (row_start || frame_start) ? '0 : next_q;
  assign dark_now = frame_start ? 1'b1 : (row_start ? 1'b0 : dark_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q <= '0;
      dark_q <= 1'b0;
    end else if (vld) begin
      next_q <= (col == CW'(NCOLS - 1)) ? '0 : col + 1'b1;
      dark_q <= dark_now;
    end
  end

  // R8: idle cycles leave the column index where it was
  a_r8_hold_col: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(next_q));
endmodule

// File: rtl/dark_line.sv
module dark_line #(
  parameter int NCOLS = 64,
  parameter int PIX_W = 12,
  localparam int CW = (NCOLS > 1) ? $clog2(NCOLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [CW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [NCOLS];

  generate
    for (genvar g = 0; g < NCOLS; g++) begin : g_col
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem[g] <= '0;
        else if (we && (waddr == CW'(g)))
          mem[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem[raddr];

  // R3: a dark sample lands in the addressed column
  a_r3_store_column: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dark_ref_sub.sv
module dark_ref_sub
  import dark_ref_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int NCOLS = 64,
  localparam int CW = (NCOLS > 1) ? $clog2(NCOLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_frame_start,
  input  logic             in_row_start,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_row_start,
  output logic             uncalibrated
);
  logic [CW-1:0]    col;
  logic             dark_now;
  logic [PIX_W-1:0] offs;
  logic             dark_wr;
  logic             img_pix;
  logic [PIX_W-1:0] corrected;
  logic             calib_q;

  col_tracker #(.NCOLS(NCOLS)) u_col (
    .clk(clk), .rst_n(rst_n), .vld(in_valid),
    .row_start(in_row_start), .frame_start(in_frame_start),
    .col(col), .dark_now(dark_now)
  );

  assign dark_wr = in_valid && dark_now;
  assign img_pix = in_valid && !dark_now;

  dark_line #(.NCOLS(NCOLS), .PIX_W(PIX_W)) u_line (
    .clk(clk), .rst_n(rst_n), .we(dark_wr), .waddr(col), .wdata(in_data),
    .raddr(col), .rdata(offs)
  );

  assign corrected = calib_q ? PIX_W'(floor_sub(32'(in_data), 32'(offs))) : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_row_start <= 1'b0;
      calib_q       <= 1'b0;
    end else begin
      out_valid     <= img_pix;
      out_row_start <= img_pix && in_row_start;
      if (img_pix) out_data <= corrected;
      if (dark_wr) calib_q <= 1'b1;
    end
  end

  assign uncalibrated = !calib_q;

  // R2: dark-row pixels are swallowed
  a_r2_dark_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dark_wr |=> !out_valid);
  // R4: every image pixel emerges one cycle later
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    img_pix |=> out_valid);
  // R5: correction never exceeds the raw pixel (no wrap)
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data <= $past(in_data));
  // R6: calibrated state is sticky
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !uncalibrated |=> !uncalibrated);
  // R6: uncalibrated pixels pass untouched
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (img_pix && uncalibrated) |=> out_data == $past(in_data));
endmodule

// File: tb/dark_ref_sub_test.sv
module dark_ref_sub_test;
  localparam int PIX_W = 12;
  localparam int NCOLS = 64;
  localparam int ROWW  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [PIX_W-1:0] in_data = '0;
  logic             in_frame_start = 1'b0;
  logic             in_row_start = 1'b0;
  logic             out_valid;
  logic [PIX_W-1:0] out_data;
  logic             out_row_start;
  logic             uncalibrated;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dark_ref_sub #(.PIX_W(PIX_W), .NCOLS(NCOLS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_frame_start(in_frame_start), .in_row_start(in_row_start),
    .out_valid(out_valid), .out_data(out_data), .out_row_start(out_row_start),
    .uncalibrated(uncalibrated)
  );

  // bench model state
  int          m_dark [NCOLS];
  bit          m_cal = 1'b0;
  bit          m_indark = 1'b0;
  int          m_col = 0;
  logic [PIX_W:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int pix, input bit fs, input bit rs);
    int e;
    @(negedge clk);
    in_valid = 1'b1; in_data = PIX_W'(pix); in_frame_start = fs; in_row_start = rs;
    if (fs || rs) m_col = 0;
    if (fs) m_indark = 1'b1; else if (rs) m_indark = 1'b0;
    if (m_indark) begin
      m_dark[m_col] = pix;
      m_cal = 1'b1;
    end else begin
      if (!m_cal) begin e = pix; tag_q.push_back("R6"); end
      else if (m_dark[m_col] > pix) begin e = 0; tag_q.push_back("R5"); end
      else begin e = pix - m_dark[m_col]; tag_q.push_back(m_dark[m_col] == 0 ? "R4" : "R9/R4"); end
      exp_q.push_back({rs, PIX_W'(e)});
    end
    m_col++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_frame_start = 1'b0; in_row_start = 1'b0;
      in_data = 12'hFFF;
    end
  endtask

  task automatic send_row(input int base, input int step, input bit fs, input bit gaps);
    for (int c = 0; c < ROWW; c++) begin
      send((base + c * step) % 4096, fs && c == 0, c == 0);
      if (gaps && c == 3) idle(2);
    end
  endtask

  // scoreboard monitor
  initial begin
    logic [PIX_W:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R8 unexpected output", int'(out_data), -1);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e[PIX_W-1:0], t, int'(out_data), int'(e[PIX_W-1:0]));
          check(out_row_start == e[PIX_W], "R7", int'(out_row_start), int'(e[PIX_W]));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCOLS; i++) m_dark[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(uncalibrated == 1'b1, "R1 uncalibrated", int'(uncalibrated), 1);

    // R6: image rows before any dark row pass through
    send_row(500, 13, 1'b0, 1'b0);
    send_row(7, 1, 1'b0, 1'b0);
    idle(2);
    check(uncalibrated == 1'b1, "R6 still uncal", int'(uncalibrated), 1);

    // frame A: dark row, then R2 check of silence and R6 flag drop
    send(40, 1'b1, 1'b1);
    idle(1);
    check(uncalibrated == 1'b0, "R6 flag cleared", int'(uncalibrated), 0);
    check(out_valid == 1'b0, "R2 dark pixel silent", int'(out_valid), 0);
    for (int c = 1; c < ROWW; c++) send(40 + c * 25, 1'b0, 1'b0);
    idle(1);
    check(out_valid == 1'b0, "R2 dark row silent", int'(out_valid), 0);
    send_row(1000, 50, 1'b0, 1'b0);   // R4 normal
    send_row(30, 20, 1'b0, 1'b1);     // R5 clamps, R8 gaps mid-row
    send_row(40, 25, 1'b0, 1'b0);     // equal -> 0
    // frame B back to back: new dark row, R9
    send_row(300, 7, 1'b1, 1'b0);
    send_row(310, 7, 1'b0, 1'b0);
    send_row(4095, 0, 1'b0, 1'b1);
    send_row(0, 0, 1'b0, 1'b0);
    // frame C with gaps inside the dark row (R3/R8 column indexing)
    send_row(5, 100, 1'b1, 1'b1);
    send_row(900, 3, 1'b0, 1'b0);
    idle(4);
    check(exp_q.size() == 0, "R4 all outputs seen", exp_q.size(), 0);

    // reset again: R1 and R6 re-arm
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_cal = 1'b0; m_indark = 1'b0;
    for (int i = 0; i < NCOLS; i++) m_dark[i] = 0;
    @(negedge clk);
    check(uncalibrated == 1'b1, "R1 uncal after reset", int'(uncalibrated), 1);
    send_row(123, 11, 1'b0, 1'b0);
    idle(3);
    check(exp_q.size() == 0, "R6 passthrough drained", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule